// File: doc/BRIEF.md
# Protection Bounds and Interrupt Flag Unit

This block guards a processor's address space and collects its interrupt causes. Every instruction fetch address is compared against a pair of instruction window registers, and every operand address against a pair of data window registers. In each pair the lower bound is inclusive and the upper bound is exclusive. A fetch outside its window always raises a fault flag. An operand access outside its window raises a fault flag only when a mode bit allows it.

The same block holds the sticky interrupt flag register. Bits are set by floating-point faults, correctable and uncorrectable memory errors, an internal countdown timer, error-exit and normal-exit instructions, and several external events. Each source is gated by its own enable or by the monitor-mode bits. Whenever any flag is set, the block requests a context exchange. When a flag register is restored with bits still set, the request rises again at once, so software that fails to clear its flags is interrupted again.

Top module: `prot_flag_unit`

## Requirements
- R1: A valid fetch whose address is below `inst_base` or at least `inst_limit` sets flag bit 6 on the next clock edge. An address in [inst_base, inst_limit) sets no flag.
- R2: A valid operand access whose address is below `data_base` or at least `data_limit` sets flag bit 5 on the next edge, but only while `en_opnd_rng` is 1. An address in [data_base, data_limit) never sets it.
- R3: `fp_err` sets flag bit 4 only while `en_fp_int` is 1. It sets the `fp_status` output whatever the value of `en_fp_int`. `fp_status` is cleared by `fp_status_clr`, and a simultaneous `fp_err` wins over the clear.
- R4: `corr_err` sets flag bit 7 only while `en_corr_err` is 1. `uncorr_err` sets flag bit 7 only while `en_uncorr_err` is 1.
- R5: `err_exit` sets flag bit 9 only while `monitor_mode` is 0.
- R6: `norm_exit` sets flag bit 10 only while both `monitor_mode` and `int_monitor_mode` are 0.
- R7: `tmr_load` loads `tmr_value` into the countdown timer. The timer then falls by one on each edge. The edge on which it reaches zero sets flag bit 2. A loaded value of zero never sets the flag.
- R8: Without any gating, `ip_irq` sets bit 0, `deadlock` sets bit 1, `chan_done` sets bit 3 and `io_irq` sets bit 8.
- R9: `xchg_req` is 1 exactly while any flag bit is 1. This includes the cycle after a restore that writes a nonzero value.
- R10: Flags are sticky. `flag_wr` replaces the whole register with `flag_wdata`, and events in the same cycle are ORed on top of the written value.
- R11: After reset, `flags`, `fp_status` and `xchg_req` are 0 and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_base | input | AW | Lowest legal fetch address |
| inst_limit | input | AW | First illegal fetch address above the window |
| fetch_valid | input | 1 | Fetch address strobe |
| fetch_addr | input | AW | Fetch address |
| data_base | input | AW | Lowest legal operand address |
| data_limit | input | AW | First illegal operand address above the window |
| opnd_valid | input | 1 | Operand address strobe |
| opnd_addr | input | AW | Operand address |
| en_opnd_rng | input | 1 | Enable for operand range interrupt |
| en_fp_int | input | 1 | Enable for floating-point interrupt |
| en_corr_err | input | 1 | Enable for correctable memory error interrupt |
| en_uncorr_err | input | 1 | Enable for uncorrectable memory error interrupt |
| monitor_mode | input | 1 | Monitor mode active |
| int_monitor_mode | input | 1 | Interrupt-monitor mode active |
| fp_err | input | 1 | Floating-point range error pulse |
| corr_err | input | 1 | Correctable memory error pulse |
| uncorr_err | input | 1 | Uncorrectable memory error pulse |
| err_exit | input | 1 | Error-exit instruction pulse |
| norm_exit | input | 1 | Normal-exit instruction pulse |
| ip_irq | input | 1 | Interprocessor interrupt pulse |
| deadlock | input | 1 | Deadlock detect pulse |
| chan_done | input | 1 | Channel-unit event pulse |
| io_irq | input | 1 | I/O interrupt pulse |
| tmr_load | input | 1 | Load the countdown timer |
| tmr_value | input | CW | Countdown start value |
| flag_wr | input | 1 | Restore or clear the flag register |
| flag_wdata | input | NF | Value written by flag_wr |
| fp_status_clr | input | 1 | Clear fp_status |
| flags | output | NF | Interrupt flag register |
| fp_status | output | 1 | Floating-point error status bit |
| xchg_req | output | 1 | Exchange request |

## Verification
The assertions assume that the event inputs are single-cycle pulses sampled on the rising edge, and that the window registers and mode bits stay stable around each access. The bench drives every input on the falling edge and returns each strobe to 0 after one cycle. It also clears the register between vectors, so each check sees only the stimulus made for it. The windows are fixed with base below limit, so the inclusive and exclusive boundaries can be tested one address on each side.

// File: rtl/prot_flag_unit.sv
module prot_flag_unit #(
  parameter int AW     = 16,
  parameter int CW     = 8,
  parameter int NF     = 11,
  parameter int B_IP   = 0,
  parameter int B_DL   = 1,
  parameter int B_TMR  = 2,
  parameter int B_CHAN = 3,
  parameter int B_FP   = 4,
  parameter int B_ORNG = 5,
  parameter int B_PRNG = 6,
  parameter int B_MERR = 7,
  parameter int B_IO   = 8,
  parameter int B_ERRX = 9,
  parameter int B_NRMX = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] inst_base,
  input  logic [AW-1:0] inst_limit,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] data_base,
  input  logic [AW-1:0] data_limit,
  input  logic          opnd_valid,
  input  logic [AW-1:0] opnd_addr,
  input  logic          en_opnd_rng,
  input  logic          en_fp_int,
  input  logic          en_corr_err,
  input  logic          en_uncorr_err,
  input  logic          monitor_mode,
  input  logic          int_monitor_mode,
  input  logic          fp_err,
  input  logic          corr_err,
  input  logic          uncorr_err,
  input  logic          err_exit,
  input  logic          norm_exit,
  input  logic          ip_irq,
  input  logic          deadlock,
  input  logic          chan_done,
  input  logic          io_irq,
  input  logic          tmr_load,
  input  logic [CW-1:0] tmr_value,
  input  logic          flag_wr,
  input  logic [NF-1:0] flag_wdata,
  input  logic          fp_status_clr,
  output logic [NF-1:0] flags,
  output logic          fp_status,
  output logic          xchg_req
);

  logic [CW-1:0] tmr_cnt;
  logic [NF-1:0] set_vec;
  logic          fetch_bad, opnd_bad, tmr_zero;

  assign fetch_bad = fetch_valid && (fetch_addr < inst_base || fetch_addr >= inst_limit);
  assign opnd_bad  = opnd_valid && (opnd_addr < data_base || opnd_addr >= data_limit);
  assign tmr_zero  = !tmr_load && (tmr_cnt == CW'(1));

  always_comb begin
    set_vec         = '0;
    set_vec[B_IP]   = ip_irq;
    set_vec[B_DL]   = deadlock;
    set_vec[B_TMR]  = tmr_zero;
    set_vec[B_CHAN] = chan_done;
    set_vec[B_FP]   = fp_err && en_fp_int;
    set_vec[B_ORNG] = opnd_bad && en_opnd_rng;
    set_vec[B_PRNG] = fetch_bad;
    set_vec[B_MERR] = (corr_err && en_corr_err) || (uncorr_err && en_uncorr_err);
    set_vec[B_IO]   = io_irq;
    set_vec[B_ERRX] = err_exit && !monitor_mode;
    set_vec[B_NRMX] = norm_exit && !monitor_mode && !int_monitor_mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags     <= '0;
      fp_status <= 1'b0;
      tmr_cnt   <= '0;
    end else begin
      flags     <= (flag_wr ? flag_wdata : flags) | set_vec;
      fp_status <= fp_err || (fp_status && !fp_status_clr);
      if (tmr_load)            tmr_cnt <= tmr_value;
      else if (tmr_cnt != '0)  tmr_cnt <= tmr_cnt - CW'(1);
    end
  end

  assign xchg_req = |flags;

endmodule

// File: rtl/prot_flag_unit_chk.sv
module prot_flag_unit_chk #(
  parameter int AW     = 16,
  parameter int NF     = 11,
  parameter int B_ORNG = 5,
  parameter int B_PRNG = 6,
  parameter int B_ERRX = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] inst_base,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_addr,
  input logic [AW-1:0] data_limit,
  input logic          opnd_valid,
  input logic [AW-1:0] opnd_addr,
  input logic          en_opnd_rng,
  input logic          monitor_mode,
  input logic          fp_err,
  input logic          err_exit,
  input logic          flag_wr,
  input logic [NF-1:0] flag_wdata,
  input logic [NF-1:0] flags,
  input logic          fp_status,
  input logic          xchg_req
);

  p_fetch_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_addr < inst_base |=> flags[B_PRNG]);

  p_opnd_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_valid && en_opnd_rng && opnd_addr >= data_limit |=> flags[B_ORNG]);

  p_fp_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fp_err |=> fp_status);

  p_errx_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr && err_exit && monitor_mode && !flags[B_ERRX] |=> !flags[B_ERRX]);

  p_restore_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr && flag_wdata != '0 |=> xchg_req);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> (flags & $past(flags)) == $past(flags));

endmodule

bind prot_flag_unit prot_flag_unit_chk #(
  .AW(AW), .NF(NF), .B_ORNG(B_ORNG), .B_PRNG(B_PRNG), .B_ERRX(B_ERRX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inst_base(inst_base), .fetch_valid(fetch_valid),
  .fetch_addr(fetch_addr), .data_limit(data_limit), .opnd_valid(opnd_valid),
  .opnd_addr(opnd_addr), .en_opnd_rng(en_opnd_rng), .monitor_mode(monitor_mode),
  .fp_err(fp_err), .err_exit(err_exit), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
  .flags(flags), .fp_status(fp_status), .xchg_req(xchg_req)
);

// File: tb/tb_prot_flag_unit.sv
`timescale 1ns/1ps
module tb_prot_flag_unit;
  localparam int AW = 16, CW = 8, NF = 11;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] inst_base = 16'h0100, inst_limit = 16'h0200;
  logic [AW-1:0] data_base = 16'h0400, data_limit = 16'h0800;
  logic fetch_valid = 0, opnd_valid = 0;
  logic [AW-1:0] fetch_addr = 0, opnd_addr = 0;
  logic en_opnd_rng = 0, en_fp_int = 0, en_corr_err = 0, en_uncorr_err = 0;
  logic monitor_mode = 0, int_monitor_mode = 0;
  logic fp_err = 0, corr_err = 0, uncorr_err = 0, err_exit = 0, norm_exit = 0;
  logic ip_irq = 0, deadlock = 0, chan_done = 0, io_irq = 0;
  logic tmr_load = 0;
  logic [CW-1:0] tmr_value = 0;
  logic flag_wr = 0, fp_status_clr = 0;
  logic [NF-1:0] flag_wdata = 0;
  logic [NF-1:0] flags;
  logic fp_status, xchg_req;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  prot_flag_unit dut (.*);

  // {is_operand, enable, address, expected_fault}
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'h00FF, 1'b1},
    {1'b0, 1'b1, 16'h0100, 1'b0},
    {1'b0, 1'b1, 16'h01FF, 1'b0},
    {1'b0, 1'b1, 16'h0200, 1'b1},
    {1'b1, 1'b1, 16'h03FF, 1'b1},
    {1'b1, 1'b1, 16'h0400, 1'b0},
    {1'b1, 1'b1, 16'h07FF, 1'b0},
    {1'b1, 1'b1, 16'h0800, 1'b1},
    {1'b1, 1'b0, 16'h0800, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_wr = 1; flag_wdata = '0;
    step();
    flag_wr = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    // R11 reset state
    check("R11 flags", 32'(flags), 0);
    check("R11 fp_status", 32'(fp_status), 0);
    check("R11 xchg_req", 32'(xchg_req), 0);

    // R1 / R2 boundary table
    for (int i = 0; i < NV; i++) begin
      clear_flags();
      if (VEC[i][18]) begin
        opnd_valid = 1; opnd_addr = VEC[i][16:1]; en_opnd_rng = VEC[i][17];
      end else begin
        fetch_valid = 1; fetch_addr = VEC[i][16:1];
      end
      step();
      fetch_valid = 0; opnd_valid = 0;
      if (VEC[i][18])
        check("R2 operand window", 32'(flags), VEC[i][0] ? 32'h020 : 0);
      else
        check("R1 fetch window", 32'(flags), VEC[i][0] ? 32'h040 : 0);
    end
    en_opnd_rng = 0;

    // R3 floating-point enable and status
    clear_flags();
    fp_err = 1; step(); fp_err = 0;
    check("R3 fp masked flags", 32'(flags), 0);
    check("R3 fp status unmasked", 32'(fp_status), 1);
    fp_status_clr = 1; step(); fp_status_clr = 0;
    check("R3 fp status clear", 32'(fp_status), 0);
    en_fp_int = 1; fp_err = 1; step(); fp_err = 0; en_fp_int = 0;
    check("R3 fp enabled", 32'(flags), 32'h010);

    // R4 memory errors
    clear_flags();
    corr_err = 1; step(); corr_err = 0;
    check("R4 corr masked", 32'(flags), 0);
    en_corr_err = 1; uncorr_err = 1; step(); uncorr_err = 0;
    check("R4 uncorr masked", 32'(flags), 0);
    corr_err = 1; step(); corr_err = 0; en_corr_err = 0;
    check("R4 corr enabled", 32'(flags), 32'h080);
    clear_flags();
    en_uncorr_err = 1; uncorr_err = 1; step(); uncorr_err = 0; en_uncorr_err = 0;
    check("R4 uncorr enabled", 32'(flags), 32'h080);

    // R5 error exit
    clear_flags();
    monitor_mode = 1; err_exit = 1; step(); err_exit = 0;
    check("R5 exit in monitor", 32'(flags), 0);
    monitor_mode = 0; err_exit = 1; step(); err_exit = 0;
    check("R5 exit in user", 32'(flags), 32'h200);

    // R6 normal exit
    clear_flags();
    int_monitor_mode = 1; norm_exit = 1; step(); norm_exit = 0;
    check("R6 exit int-monitor", 32'(flags), 0);
    int_monitor_mode = 0; monitor_mode = 1; norm_exit = 1; step(); norm_exit = 0;
    check("R6 exit monitor", 32'(flags), 0);
    monitor_mode = 0; norm_exit = 1; step(); norm_exit = 0;
    check("R6 exit user", 32'(flags), 32'h400);

    // R7 countdown timer
    clear_flags();
    tmr_load = 1; tmr_value = 3; step(); tmr_load = 0;
    step(); step();
    check("R7 timer before zero", 32'(flags), 0);
    step();
    check("R7 timer reaches zero", 32'(flags), 32'h004);
    clear_flags();
    tmr_load = 1; tmr_value = 0; step(); tmr_load = 0;
    for (int k = 0; k < 5; k++) step();
    check("R7 zero load silent", 32'(flags), 0);

    // R8 ungated events
    clear_flags();
    ip_irq = 1; deadlock = 1; chan_done = 1; io_irq = 1; step();
    ip_irq = 0; deadlock = 0; chan_done = 0; io_irq = 0;
    check("R8 ungated events", 32'(flags), 32'h10B);
    check("R9 request on events", 32'(xchg_req), 1);

    // R10 stickiness
    step(); step(); step();
    check("R10 sticky", 32'(flags), 32'h10B);

    // R9 / R10 restore
    flag_wr = 1; flag_wdata = 11'h040; step(); flag_wr = 0;
    check("R10 restore replaces", 32'(flags), 32'h040);
    check("R9 restore re-request", 32'(xchg_req), 1);
    clear_flags();
    check("R9 request drops", 32'(xchg_req), 0);
    flag_wr = 1; flag_wdata = 11'h001; io_irq = 1; step(); flag_wr = 0; io_irq = 0;
    check("R10 write plus event", 32'(flags), 32'h101);

    finish_run();
  end
endmodule